// File: doc/BRIEF.md
# Subsystem Power-Up Reset Sequencer

This block is a state machine that takes a processor subsystem from its held-in-reset condition to running code. It owns three control register images: a core reset register, a power-control register and a clock-mux register. It changes them one read-modify-write step at a time in a fixed order. After the power switch turns on, it waits a settling time measured in microsecond ticks. It switches the data-memory banks on one at a time, with a minimum gap in clock cycles between them, to limit inrush current. It removes the I/O clamp and then frees the core. Last, it enables the core clock and lets the core run.

When the core runs, the sequencer watches a boot status input. A nonzero value ends the wait. Only the value 1 counts as success and gives `done_o`. Any other nonzero value gives `err_o`. If the status is still zero after the boot timeout, the result is also `err_o`. The result flag stays set until the next accepted start. A start request that arrives while the sequence is running is ignored.

Top module: `subsys_pwrup_seq`

## Requirements
- R1: After reset the reset image is 0, the power image holds only bit 20 (I/O clamp), the clock image is 0, and `busy_o`, `done_o` and `err_o` are low.
- R2: Two cycles after a start is sampled in idle, one write sets reset-image bits 0 (stop core), 1 (core reset) and 2 (bus reset) together.
- R3: The next write sets power bits 21 (head switch) and 22 (regulator bypass) together. More than SETTLE_US microsecond ticks must then pass before the next power write.
- R4: The next write sets power bits 16 (tag memory), 17 (trace buffer), 18 (data standby) and 19 (sleep retention) in one step, one cycle after the settle wait ends.
- R5: The data-bank enables (power bits NBANK-1 down to 0) are set one per write, highest bank first. Consecutive bank writes are exactly BANK_GAP cycles apart, and the first bank write follows the memory write by one cycle.
- R6: After the last bank write, power bit 20 is cleared, and then reset bit 1 is cleared. The clamp is always clear when the core reset falls.
- R7: Clock-mux bit 1 is then set, and only after that is reset bit 0 cleared. Reset bit 2 stays set. The final images are 0x4, 0x006F0007 and 0x2.
- R8: Each write takes one cycle, and at most one of the three register images changes in any cycle.
- R9: Once the stop bit is cleared, a nonzero boot status ends the sequence. The value 1 sets `done_o`, and any other nonzero value sets `err_o`.
- R10: If the boot status stays zero for more than BOOT_TIMEOUT_US ticks, the sequence ends with `err_o`, and a later value of 1 does not change it.
- R11: A start asserted while `busy_o` is high has no effect: the sequence finishes in the same number of cycles as without it.
- R12: `busy_o` is high from the accepted start until the result. `done_o` and `err_o` are never both high and are held until the next accepted start, which clears them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled in idle |
| boot_stat_i | input | STAT_W | Boot status reported by the core |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| rst_img_o | output | 32 | Core reset register image |
| pwr_img_o | output | 32 | Power-control register image |
| clk_img_o | output | 32 | Clock-mux register image |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Boot succeeded |
| err_o | output | 1 | Boot failed or timed out |

## Verification
The assertions take three things for granted about the inputs. Reset lasts at least one full cycle. The microsecond tick is a single-cycle pulse. The boot status is read only in the final wait. The stimulus keeps the status at zero until the clock enable and the cleared stop bit are both visible at the ports. It pulses start for one cycle and drives the tick every fourth cycle, in phase with reset release, so each run's timing repeats exactly. The sweep covers every status value of a 4-bit configuration, with the arrival time growing with the value, plus one late arrival after the timeout.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int IMG_W = 32;

    // reset register fields
    localparam int RST_STOP = 0;
    localparam int RST_CORE = 1;
    localparam int RST_BUS  = 2;

    // power-control register fields
    localparam int PWR_TAG   = 16;
    localparam int PWR_TRACE = 17;
    localparam int PWR_STBY  = 18;
    localparam int PWR_RET   = 19;
    localparam int PWR_CLAMP = 20;
    localparam int PWR_HSW   = 21;
    localparam int PWR_BYP   = 22;

    // clock-mux register field
    localparam int CLK_CORE_EN = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_HSW,
        ST_SETTLE,
        ST_MEM,
        ST_BANK,
        ST_UNCLAMP,
        ST_CORE,
        ST_CLKEN,
        ST_GO,
        ST_BOOT
    } seq_state_e;

    typedef struct packed {
        logic [IMG_W-1:0] rst_r;
        logic [IMG_W-1:0] pwr_r;
        logic [IMG_W-1:0] clk_r;
    } reg_img_t;

    function automatic logic [IMG_W-1:0] bit_mask(input int pos);
        return {{(IMG_W-1){1'b0}}, 1'b1} << pos;
    endfunction

    localparam logic [IMG_W-1:0] PWR_AT_RESET = {{(IMG_W-1){1'b0}}, 1'b1} << PWR_CLAMP;

endpackage

// File: rtl/pwrseq_tick_timer.sv
module pwrseq_tick_timer #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] cnt;

    // expired only after LIMIT+1 ticks, so a full LIMIT microseconds have elapsed
    assign expired = (cnt > CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrseq_gap_counter.sv
module pwrseq_gap_counter #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);
    localparam int CW = (GAP > 1) ? $clog2(GAP + 1) : 1;

    logic [CW-1:0] cnt;

    assign ready = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(GAP - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/subsys_pwrup_seq.sv
module subsys_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int STAT_W          = 8,
    parameter int NBANK           = 3,
    parameter int BANK_GAP        = 4,
    parameter int SETTLE_US       = 1,
    parameter int BOOT_TIMEOUT_US = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [STAT_W-1:0] boot_stat_i,
    input  logic              us_tick_i,
    output logic [31:0]       rst_img_o,
    output logic [31:0]       pwr_img_o,
    output logic [31:0]       clk_img_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int SB_W  = $clog2(BANK_GAP + 2);

    seq_state_e       state, nxt;
    reg_img_t         img;
    logic [IDX_W-1:0] bank_idx;
    logic             settle_ok, boot_expired, gap_ok, bank_wr;
    logic             stat_seen, boot_good;
    logic             done_q, err_q;

    assign stat_seen = |boot_stat_i;
    assign boot_good = (boot_stat_i == STAT_W'(1));
    assign bank_wr   = (state == ST_BANK) && gap_ok;

    pwrseq_tick_timer #(.LIMIT(SETTLE_US)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_SETTLE),
        .tick    (us_tick_i),
        .expired (settle_ok)
    );

    pwrseq_tick_timer #(.LIMIT(BOOT_TIMEOUT_US)) u_boot (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_BOOT),
        .tick    (us_tick_i),
        .expired (boot_expired)
    );

    pwrseq_gap_counter #(.GAP(BANK_GAP)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .load  (bank_wr),
        .ready (gap_ok)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_i) nxt = ST_HALT;
            ST_HALT:    nxt = ST_HSW;
            ST_HSW:     nxt = ST_SETTLE;
            ST_SETTLE:  if (settle_ok) nxt = ST_MEM;
            ST_MEM:     nxt = ST_BANK;
            ST_BANK:    if (bank_wr && bank_idx == '0) nxt = ST_UNCLAMP;
            ST_UNCLAMP: nxt = ST_CORE;
            ST_CORE:    nxt = ST_CLKEN;
            ST_CLKEN:   nxt = ST_GO;
            ST_GO:      nxt = ST_BOOT;
            ST_BOOT:    if (stat_seen || boot_expired) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            img.rst_r <= '0;
            img.pwr_r <= PWR_AT_RESET;
            img.clk_r <= '0;
            bank_idx  <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state <= nxt;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                ST_HALT:
                    img.rst_r <= img.rst_r | bit_mask(RST_STOP) | bit_mask(RST_CORE)
                                           | bit_mask(RST_BUS);
                ST_HSW:
                    img.pwr_r <= img.pwr_r | bit_mask(PWR_HSW) | bit_mask(PWR_BYP);
                ST_MEM: begin
                    img.pwr_r <= img.pwr_r | bit_mask(PWR_RET) | bit_mask(PWR_TAG)
                                           | bit_mask(PWR_TRACE) | bit_mask(PWR_STBY);
                    bank_idx  <= IDX_W'(NBANK - 1);
                end
                ST_BANK: begin
                    if (bank_wr) begin
                        img.pwr_r[bank_idx] <= 1'b1;
                        if (bank_idx != '0) bank_idx <= bank_idx - 1'b1;
                    end
                end
                ST_UNCLAMP: img.pwr_r[PWR_CLAMP]   <= 1'b0;
                ST_CORE:    img.rst_r[RST_CORE]    <= 1'b0;
                ST_CLKEN:   img.clk_r[CLK_CORE_EN] <= 1'b1;
                ST_GO:      img.rst_r[RST_STOP]    <= 1'b0;
                ST_BOOT: begin
                    if (stat_seen) begin
                        done_q <= boot_good;
                        err_q  <= !boot_good;
                    end else if (boot_expired) begin
                        err_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rst_img_o = img.rst_r;
    assign pwr_img_o = img.pwr_r;
    assign clk_img_o = img.clk_r;
    assign busy_o    = (state != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic            past_ok;
    logic [NBANK-1:0] bank_prev;
    logic [SB_W-1:0] since_bank;
    logic            bank_rise;

    assign bank_rise = |(img.pwr_r[NBANK-1:0] & ~bank_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok    <= 1'b0;
            bank_prev  <= '0;
            since_bank <= '0;
        end else begin
            past_ok   <= 1'b1;
            bank_prev <= img.pwr_r[NBANK-1:0];
            if (bank_rise)
                since_bank <= SB_W'(1);
            else if (since_bank < SB_W'(BANK_GAP))
                since_bank <= since_bank + 1'b1;
        end
    end

    // R8
    one_write_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ($countones({rst_img_o != $past(rst_img_o),
                                 pwr_img_o != $past(pwr_img_o),
                                 clk_img_o != $past(clk_img_o)}) <= 1));

    // R2
    halt_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> (rst_img_o[2:0] == 3'b111));

    // R6
    clamp_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_img_o[RST_CORE]) |-> !pwr_img_o[PWR_CLAMP]);

    // R7
    clk_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_img_o[RST_STOP]) |-> clk_img_o[CLK_CORE_EN]);

    // R5
    bank_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_rise && bank_prev[NBANK-1]) |-> (since_bank >= SB_W'(BANK_GAP)));

    generate
        for (genvar b = 0; b < NBANK - 1; b++) begin : g_order
            // R5
            bank_order_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(pwr_img_o[b]) |-> (&pwr_img_o[NBANK-1:b+1]));
        end
    endgenerate

    // R9
    done_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BOOT && boot_stat_i == STAT_W'(1)) |=> (done_o && !busy_o));

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o) && !(busy_o && (done_o || err_o)));

endmodule

// File: tb/test_subsys_pwrup_seq.sv
module test_subsys_pwrup_seq;
    localparam int STAT_W = 4;
    localparam int NBANK  = 3;
    localparam int GAP    = 3;
    localparam int SETTLE = 2;
    localparam int TMO    = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [STAT_W-1:0] stat = '0;
    logic us_tick = 1'b0;
    logic [31:0] rst_img, pwr_img, clk_img;
    logic busy, done, err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int base = 0;
    int nticks = 0;

    int t_halt, t_hs, t_mem, t_unc, t_core, t_clk, t_go, t_end;
    int k_hs, k_mem;
    int t_b[NBANK];
    logic [31:0] p_rst, p_pwr, p_clk;
    logic p_busy;

    always #10 clk = ~clk;

    subsys_pwrup_seq #(
        .STAT_W(STAT_W), .NBANK(NBANK), .BANK_GAP(GAP),
        .SETTLE_US(SETTLE), .BOOT_TIMEOUT_US(TMO)
    ) i_subsys_pwrup_seq (
        .clk(clk), .rst(rst), .start_i(start), .boot_stat_i(stat),
        .us_tick_i(us_tick), .rst_img_o(rst_img), .pwr_img_o(pwr_img),
        .clk_img_o(clk_img), .busy_o(busy), .done_o(done), .err_o(err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor and tick generator, both at the falling edge
    always @(negedge clk) begin
        if (us_tick) nticks = nticks + 1;
        if (!p_rst[1] && rst_img[1]) t_halt = cyc;
        if (p_rst[1] && !rst_img[1]) t_core = cyc;
        if (p_rst[0] && !rst_img[0]) t_go = cyc;
        if (!p_pwr[21] && pwr_img[21]) begin t_hs = cyc; k_hs = nticks; end
        if (!p_pwr[19] && pwr_img[19]) begin t_mem = cyc; k_mem = nticks; end
        if (p_pwr[20] && !pwr_img[20]) t_unc = cyc;
        for (int b = 0; b < NBANK; b++)
            if (!p_pwr[b] && pwr_img[b]) t_b[b] = cyc;
        if (!p_clk[1] && clk_img[1]) t_clk = cyc;
        if (p_busy && !busy) t_end = cyc;
        p_rst = rst_img; p_pwr = pwr_img; p_clk = clk_img; p_busy = busy;
        us_tick = (((cyc - base) % 4) == 3);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; stat = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        base = cyc;
    endtask

    // one full run: status value s arrives dly cycles after the core is released
    task automatic run_seq(input int s, input int dly, input bit poke, output int dur);
        int t0;
        do_reset();
        repeat (2) @(negedge clk);
        start = 1'b1; t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (9) @(negedge clk);
            start = 1'b1;                // R11 start while busy
            @(negedge clk);
            start = 1'b0;
            repeat (8) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 2000; i++) begin
            if (clk_img[1] && !rst_img[0]) break;
            @(negedge clk);
        end
        repeat (dly) @(negedge clk);
        stat = STAT_W'(s);
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
        stat = '0;
        dur = t_end - t0;
        chk(t_halt == t0 + 2, "R2", "halt write cycle", t_halt, t0 + 2);
        chk(t_hs == t_halt + 1, "R3", "head switch after halt", t_hs, t_halt + 1);
        chk(k_mem - k_hs > SETTLE, "R3", "settle ticks", k_mem - k_hs, SETTLE + 1);
        chk(t_b[NBANK-1] == t_mem + 1, "R4", "first bank after mem", t_b[NBANK-1], t_mem + 1);
        for (int b = NBANK - 2; b >= 0; b--)
            chk(t_b[b] - t_b[b+1] == GAP, "R5", "bank spacing", t_b[b] - t_b[b+1], GAP);
        chk(t_unc == t_b[0] + 1, "R6", "clamp release", t_unc, t_b[0] + 1);
        chk(t_core == t_unc + 1, "R6", "core reset release", t_core, t_unc + 1);
        chk(t_clk == t_core + 1, "R7", "clock enable", t_clk, t_core + 1);
        chk(t_go == t_clk + 1, "R8", "stop cleared next cycle", t_go, t_clk + 1);
        chk(rst_img == 32'h4, "R7", "final reset image", rst_img, 32'h4);
        chk(pwr_img == 32'h006F0007, "R7", "final power image", pwr_img, 32'h006F0007);
        chk(clk_img == 32'h2, "R7", "final clock image", clk_img, 32'h2);
    endtask

    initial begin
        int d_base, d;
        p_rst = '0; p_pwr = '0; p_clk = '0; p_busy = 1'b0;
        do_reset();
        @(negedge clk);
        // R1
        chk(rst_img == 0, "R1", "reset image", rst_img, 0);
        chk(pwr_img == 32'h00100000, "R1", "power image", pwr_img, 32'h00100000);
        chk(clk_img == 0, "R1", "clock image", clk_img, 0);
        chk({busy, done, err} == 3'b000, "R1", "flags", {busy, done, err}, 0);

        run_seq(1, 5, 1'b0, d_base);
        chk(done && !err, "R9", "baseline done", {done, err}, 2'b10);

        // sweep every status value, arrival delay grows with the value
        for (int s = 0; s < (1 << STAT_W); s++) begin
            run_seq(s, 1 + 3 * s, 1'b0, d);
            if (s == 0)
                chk(err && !done, "R10", "timeout with zero status", {done, err}, 2'b01);
            else if (s == 1)
                chk(done && !err, "R9", "status 1 gives done", {done, err}, 2'b10);
            else
                chk(err && !done, "R9", "other status gives error", {done, err}, 2'b01);
            chk(!busy, "R12", "busy low at end", busy, 0);
        end

        // R10 success value after the timeout is ignored
        run_seq(1, 200, 1'b0, d);
        chk(err && !done, "R10", "late status 1", {done, err}, 2'b01);

        // R11 starts while busy
        run_seq(1, 5, 1'b1, d);
        chk(d == d_base, "R11", "duration with start pokes", d, d_base);
        chk(done && !err, "R11", "result with start pokes", {done, err}, 2'b10);

        // R12 result held, cleared by next start
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i % 5 == 0)
                chk(done && !err && !busy, "R12", "done held", {busy, done, err}, 3'b010);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !err, "R12", "start clears done", {busy, done, err}, 3'b100);
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk(err && !done, "R10", "rerun without status times out", {done, err}, 2'b01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual busy %0d expected run to end", busy);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule